// File: doc/BRIEF.md
# Prioritized Interrupt Vector Fetch Unit

This unit carries out the single-byte "jump through the vector table" operation of a small 8-bit controller core. A pulse on `start`, given with the address of the vectoring instruction, picks the highest-ranked interrupt source that is both pending and enabled. From that rank and the instruction address it computes a table slot, reads a two-byte entry through a synchronous program-memory read port, and hands back a 15-bit jump target with a one-cycle `done` strobe.

The table sits in the top 32 bytes of a 256-byte page. Normally this is the page that holds the instruction. When the instruction is the last byte of its page, the table is in the page after it, and that wraps around the 32 KB space. Rank 0 owns the lowest pair of bytes and rank 15 (the software trap) owns the highest pair. Every operation takes the same number of cycles, including one where nothing is eligible.

Top module: `vf_unit`

## Requirements
- R1: The selected rank is the highest index i for which `irq_pend[i]` and `irq_en[i]` are both 1. Its entry's high byte is at page offset 8'hE0 + 2*i.
- R2: Bit 15 is the software trap. When `irq_pend[15]` is 1 it is selected whatever `irq_en[15]` holds, and its entry is at offsets 8'hFE/8'hFF.
- R3: When no source is eligible, rank 0 is used (offsets 8'hE0/8'hE1).
- R4: The table page is `pc_in[14:8]`. If `pc_in[7:0]` is 8'hFF, the page is `pc_in[14:8]`+1 modulo 128, so page 7'h7F moves to page 0.
- R5: In the first cycle after the start is accepted, `mem_rd` is 1 with `mem_addr` on the high-byte (even) address. In the second cycle `mem_rd` is 1 with the address plus one. In the third cycle `mem_rd` is 0 and the address is held. Read data arrives one cycle after the address.
- R6: `pc_out` = {high byte bits 6..0, low byte bits 7..0}. Bit 7 of the high byte is dropped.
- R7: A start accepted at edge E raises `busy` for the three cycles after E. `done` is 1 for exactly the cycle after edge E+3, and `busy` is 0 in that cycle. `pc_out` takes the new value in that same cycle and does not change at any other time.
- R8: `start` is ignored while `busy` is 1. The operation in progress completes unchanged and no second operation follows.
- R9: After reset, `busy`, `done` and `mem_rd` are 0 and `pc_out` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a vector fetch (accepted when not busy) |
| pc_in | input | 15 | Address of the vectoring instruction |
| irq_pend | input | 16 | Pending flags, bit i = rank i, bit 15 = software trap |
| irq_en | input | 16 | Enable flags, bit i = rank i |
| mem_addr | output | 15 | Program-memory read address |
| mem_rd | output | 1 | Read request |
| mem_rdata | input | 8 | Read data, valid one cycle after the address |
| busy | output | 1 | Fetch sequence in progress |
| done | output | 1 | One-cycle strobe when `pc_out` is loaded |
| pc_out | output | 15 | Jump target |

## Verification
The bench aims at the page arithmetic. It places instructions at offset FF, at the top of the last page and one byte below a page end. A design that forgets the page advance, or does not wrap it, reads a table from the wrong page. It mixes pending and enable masks so that the highest pending source is masked, sets a trap with its enable bit clear, and gives cases with nothing eligible. A wrong priority encoder, or one that gates the trap, lands on the wrong slot. A memory that returns all ones exposes a target that keeps the high byte's top bit. A second start pulse given while busy exposes a sequencer that restarts or queues work.

// File: rtl/vf_pkg.sv
package vf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HI   = 2'd1,
    ST_LO   = 2'd2,
    ST_WAIT = 2'd3
  } vf_state_e;
endpackage

// File: rtl/vf_prio.sv
// Picks the highest eligible rank; the top rank ignores its enable.
module vf_prio #(
  parameter int SRC_N  = 16,
  parameter int SLOT_W = $clog2(SRC_N)
) (
  input  logic [SRC_N-1:0]  pend_i,
  input  logic [SRC_N-1:0]  en_i,
  output logic [SLOT_W-1:0] slot_o
);
  logic [SRC_N-1:0] elig;

  for (genvar g = 0; g < SRC_N; g++) begin : g_elig
    if (g == SRC_N - 1) begin : g_trap
      assign elig[g] = pend_i[g];
    end else begin : g_mask
      assign elig[g] = pend_i[g] & en_i[g];
    end
  end

  always_comb begin
    slot_o = '0;
    for (int i = 0; i < SRC_N; i++) begin
      if (elig[i]) slot_o = SLOT_W'(i);
    end
  end
endmodule

// File: rtl/vf_addr_gen.sv
// Table page and slot offset -> address of the entry's high byte.
module vf_addr_gen #(
  parameter int PC_W   = 15,
  parameter int SRC_N  = 16,
  parameter int SLOT_W = $clog2(SRC_N)
) (
  input  logic [PC_W-1:0]   pc_i,
  input  logic [SLOT_W-1:0] slot_i,
  output logic [PC_W-1:0]   hi_addr_o
);
  localparam int PAGE_W   = PC_W - 8;
  localparam int TBL_BASE = 256 - 2 * SRC_N;

  logic [PAGE_W-1:0] page;
  logic [7:0]        offs;
  logic              at_end;

  always_comb begin
    at_end    = (pc_i[7:0] == 8'hFF);
    page      = pc_i[PC_W-1:8] + PAGE_W'(at_end);
    offs      = 8'(TBL_BASE) + 8'({slot_i, 1'b0});
    hi_addr_o = {page, offs};
  end
endmodule

// File: rtl/vf_seq.sv
// Two-byte fetch sequencer and target register.
module vf_seq
  import vf_pkg::*;
#(
  parameter int PC_W = 15,
  parameter int DW   = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [PC_W-1:0] hi_addr_i,
  input  logic [DW-1:0]   rdata_i,
  output logic [PC_W-1:0] addr_o,
  output logic            rd_o,
  output logic            busy_o,
  output logic            done_o,
  output logic [PC_W-1:0] pc_o
);
  localparam int HI_KEEP = PC_W - DW;

  vf_state_e           st_q, st_d;
  logic [PC_W-1:0]     addr_q, addr_d;
  logic [HI_KEEP-1:0]  hi_q, hi_d;
  logic [PC_W-1:0]     pc_q, pc_d;
  logic                done_q, done_d;
  logic                addr_en, hi_en, pc_en;

  always_comb begin
    st_d    = st_q;
    addr_d  = addr_q;
    hi_d    = rdata_i[HI_KEEP-1:0];
    pc_d    = {hi_q, rdata_i};
    done_d  = 1'b0;
    addr_en = 1'b0;
    hi_en   = 1'b0;
    pc_en   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d    = ST_HI;
          addr_d  = hi_addr_i;
          addr_en = 1'b1;
        end
      end
      ST_HI: begin
        st_d    = ST_LO;
        addr_d  = {addr_q[PC_W-1:1], 1'b1};
        addr_en = 1'b1;
      end
      ST_LO: begin
        st_d  = ST_WAIT;
        hi_en = 1'b1;
      end
      ST_WAIT: begin
        st_d   = ST_IDLE;
        pc_en  = 1'b1;
        done_d = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      hi_q   <= '0;
      pc_q   <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
      if (addr_en) addr_q <= addr_d;
      if (hi_en)   hi_q   <= hi_d;
      if (pc_en)   pc_q   <= pc_d;
    end
  end

  assign addr_o = addr_q;
  assign rd_o   = (st_q == ST_HI) || (st_q == ST_LO);
  assign busy_o = (st_q != ST_IDLE);
  assign done_o = done_q;
  assign pc_o   = pc_q;
endmodule

// File: rtl/vf_unit.sv
module vf_unit #(
  parameter int PC_W  = 15,
  parameter int DW    = 8,
  parameter int SRC_N = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PC_W-1:0]   pc_in,
  input  logic [SRC_N-1:0]  irq_pend,
  input  logic [SRC_N-1:0]  irq_en,
  output logic [PC_W-1:0]   mem_addr,
  output logic              mem_rd,
  input  logic [DW-1:0]     mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [PC_W-1:0]   pc_out
);
  localparam int SLOT_W = $clog2(SRC_N);

  logic [1:0]        rst_sync;
  logic              rst_ok_n;
  logic [SLOT_W-1:0] slot;
  logic [PC_W-1:0]   hi_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_ok_n = rst_sync[1];

  vf_prio #(.SRC_N(SRC_N), .SLOT_W(SLOT_W)) u_prio (
    .pend_i (irq_pend),
    .en_i   (irq_en),
    .slot_o (slot)
  );

  vf_addr_gen #(.PC_W(PC_W), .SRC_N(SRC_N), .SLOT_W(SLOT_W)) u_agen (
    .pc_i      (pc_in),
    .slot_i    (slot),
    .hi_addr_o (hi_addr)
  );

  vf_seq #(.PC_W(PC_W), .DW(DW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_ok_n),
    .start_i   (start),
    .hi_addr_i (hi_addr),
    .rdata_i   (mem_rdata),
    .addr_o    (mem_addr),
    .rd_o      (mem_rd),
    .busy_o    (busy),
    .done_o    (done),
    .pc_o      (pc_out)
  );
endmodule

// File: rtl/vf_unit_chk.sv
module vf_unit_chk #(
  parameter int PC_W  = 15,
  parameter int SRC_N = 16
) (
  input logic            clk,
  input logic            rst_ok_n,
  input logic            start,
  input logic [PC_W-1:0] mem_addr,
  input logic            mem_rd,
  input logic            busy,
  input logic            done,
  input logic [PC_W-1:0] pc_out
);
  localparam logic [7:0] TBL_LO = 8'(256 - 2 * SRC_N);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_ok_n)
    done |=> !done); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_ok_n)
    done |-> !busy); // R7
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (!busy && start) |=> (busy && mem_rd && !mem_addr[0])); // R5
  AST_LO_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (mem_rd && !mem_addr[0]) |=> (mem_rd && mem_addr == ($past(mem_addr) | PC_W'(1)))); // R5
  AST_LO_HOLD: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (mem_rd && mem_addr[0]) |=> (!mem_rd && busy && $stable(mem_addr))); // R5
  AST_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_ok_n)
    mem_rd |-> (mem_addr[7:0] >= TBL_LO)); // R1
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_ok_n)
    !done |-> $stable(pc_out)); // R7
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_ok_n)
    (busy && !mem_rd) |=> !busy); // R8
endmodule

bind vf_unit vf_unit_chk #(.PC_W(PC_W), .SRC_N(SRC_N)) u_chk (
  .clk      (clk),
  .rst_ok_n (rst_ok_n),
  .start    (start),
  .mem_addr (mem_addr),
  .mem_rd   (mem_rd),
  .busy     (busy),
  .done     (done),
  .pc_out   (pc_out)
);

// File: tb/sim_vf_unit.sv
`timescale 1ns/1ps
module sim_vf_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [14:0] pc_in;
  logic [15:0] irq_pend, irq_en;
  logic [14:0] mem_addr;
  logic        mem_rd;
  logic [7:0]  mem_rdata;
  logic        busy, done;
  logic [14:0] pc_out;
  bit          mem_ones;
  int          n_chk = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;

  vf_unit u0 (.*);

  function automatic logic [7:0] mf(input logic [14:0] a);
    return a[7:0] ^ {a[14:8], 1'b1} ^ 8'hA5;
  endfunction

  always_ff @(posedge clk) mem_rdata <= mem_ones ? 8'hFF : mf(mem_addr);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // pc, pend, en, expected high-byte address
  localparam int NV = 8;
  localparam logic [14:0] V_PC   [NV] = '{15'h00FF, 15'h0150, 15'h0234, 15'h7FFF,
                                          15'h12FF, 15'h3400, 15'h0AFE, 15'h7F10};
  localparam logic [15:0] V_PEND [NV] = '{16'h0008, 16'h0F00, 16'h8001, 16'h0004,
                                          16'h0000, 16'h00F0, 16'hFFFF, 16'h0002};
  localparam logic [15:0] V_EN   [NV] = '{16'h0008, 16'h0A00, 16'h0001, 16'h0004,
                                          16'hFFFF, 16'h000F, 16'h7FFF, 16'hFFFF};
  localparam logic [14:0] V_HI   [NV] = '{15'h01E6, 15'h01F6, 15'h02FE, 15'h00E4,
                                          15'h13E0, 15'h34E0, 15'h0AFE, 15'h7FE2};

  task automatic run_op(input logic [14:0] pc, input logic [15:0] pend, input logic [15:0] en,
                        input logic [14:0] hi, input logic [14:0] exp_pc, input string tag);
    @(negedge clk);
    pc_in = pc; irq_pend = pend; irq_en = en; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(mem_rd && busy && mem_addr == hi, {tag, " R5 high-byte read"}, {16'd0, mem_rd, mem_addr}, {17'd1, hi});
    @(negedge clk);
    chk(mem_rd && mem_addr == (hi | 15'd1), {tag, " R5 low-byte read"}, {16'd0, mem_rd, mem_addr}, {17'd1, hi | 15'd1});
    @(negedge clk);
    chk(busy && !done && !mem_rd, "R7 third busy cycle", {busy, done, mem_rd}, 3'b100);
    @(negedge clk);
    chk(done && !busy, "R7 done strobe", {done, busy}, 2'b10);
    chk(pc_out == exp_pc, {tag, " R6 target"}, pc_out, exp_pc);
    @(negedge clk);
    chk(!done && pc_out == exp_pc, "R7 done single, target held", {done, pc_out}, {1'b0, exp_pc});
  endtask

  function automatic logic [14:0] exp_target(input logic [14:0] hi);
    return {mf(hi)[6:0], mf(hi | 15'd1)};
  endfunction

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; pc_in = '0; irq_pend = '0; irq_en = '0; mem_ones = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_rd && pc_out == 15'd0, "R9 reset state", {busy, done, mem_rd, pc_out}, 18'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !mem_rd && pc_out == 15'd0, "R9 after release", {busy, done, mem_rd, pc_out}, 18'd0);

    // Table walk: R1 priority, R2 trap, R3 fallback, R4 page select and wrap
    for (int k = 0; k < NV; k++) begin
      run_op(V_PC[k], V_PEND[k], V_EN[k], V_HI[k], exp_target(V_HI[k]),
             (k == 2 || k == 6) ? "R2 trap" : (k == 4 || k == 5) ? "R3 none eligible" :
             (k == 0 || k == 3) ? "R4 page step" : "R1 priority");
    end

    // R6: high byte bit 7 must be dropped
    mem_ones = 1'b1;
    run_op(15'h0500, 16'h0010, 16'h0010, 15'h05E8, 15'h7FFF, "R6 bit7 drop");
    mem_ones = 1'b0;

    // R8: second start while busy is ignored
    @(negedge clk);
    pc_in = 15'h0150; irq_pend = 16'h0F00; irq_en = 16'h0A00; start = 1'b1;
    @(negedge clk);
    pc_in = 15'h0600; irq_pend = 16'h8000; irq_en = 16'h0000;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(done && pc_out == exp_target(15'h01F6), "R8 first op result", pc_out, exp_target(15'h01F6));
    begin
      int extra = 0;
      for (int c = 0; c < 6; c++) begin
        @(negedge clk);
        if (busy || done || mem_rd) extra++;
      end
      chk(extra == 0, "R8 no second op", extra, 0);
    end
    chk(pc_out == exp_target(15'h01F6), "R8 target kept", pc_out, exp_target(15'h01F6));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule